// File: doc/BRIEF.md
# Odd-Even Merge Network for Two Presorted Key Blocks

This block takes one flat vector of `N` unsigned keys. The vector holds two blocks of `N/2` keys, and each block is already in nondecreasing order. The block returns the same keys as a single nondecreasing sequence. The network uses only compare-exchange cells. These cells are placed in the recursive odd-even pattern: the even-indexed and odd-indexed subsequences are merged separately, and then a final column compares neighbouring lines. The network is `log2(N)` columns deep. No column holds more than `N/2` cells, and the network uses `1 + (N/2)*(log2(N)-1)` cells in total.

A parameter selects whether each column is followed by a register. With registers the latency is `log2(N)` clock cycles and the block accepts a new vector on every cycle. Without them the network is purely combinational. A valid strobe travels with the data. The block does not check that its two input blocks are sorted; the driver must guarantee it.

Top module: `oem_merge`

## Requirements
- R1: When both input blocks are nondecreasing, the keys on `out_keys` are nondecreasing from key 0 to key N-1, compared as unsigned numbers.
- R2: The output keys are a permutation of the input keys: every value appears as often at the output as it did at the input.
- R3: Output key 0 is the smaller of the two block heads, and output key N-1 is the larger of the two block tails. This holds in particular when one block lies wholly below the other.
- R4: With `REGISTERED=1`, `out_valid` equals `in_valid` from exactly log2(N) cycles earlier. With `REGISTERED=0` the delay is zero.
- R5: A new vector can be accepted on every cycle. Each vector's result appears with its own `out_valid` pulse. Idle cycles between vectors give idle output cycles at the same spacing.
- R6: While `rst_n` is low at a rising clock edge, `out_valid` is cleared and `out_keys` is zeroed (synchronous, active low).
- R7: Key i lies at bits `[i*W +: W]` of both `in_keys` and `out_keys`. Block A occupies keys 0 to N/2-1 and block B occupies keys N/2 to N-1.
- R8: Duplicate values, within a block or across the two blocks, come out with their full count. An all-equal input comes out unchanged.
- R9: Key values 0 and 2^W-1 are ordered correctly as unsigned numbers. The top bit is never treated as a sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the column registers |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_keys` as holding a vector to merge |
| in_keys | input | N*W | Block A in keys 0..N/2-1, block B in keys N/2..N-1 |
| out_valid | output | 1 | Marks `out_keys` as holding a merged result |
| out_keys | output | N*W | Merged keys, nondecreasing from key 0 upward |

## Verification
The ordering and end-value properties hold only when both input blocks are nondecreasing. The checker therefore computes that condition on the inputs, delays it alongside the data, and applies those properties only when it holds. The key-sum and latency properties apply to every vector. The bench builds each stimulus vector so that it meets this condition: it writes the halves in sorted order or sorts each half of a pseudo-random vector. It then compares the DUT output with a full sort of the whole vector, computed independently in the bench.

// File: rtl/oem_pkg.sv
// Package: shared types and elaboration-time helpers for the odd-even merge
// network. Assumes the line count n is a power of two, 2 or larger.
package oem_pkg;

    typedef enum logic [1:0] {
        LINE_PASS = 2'd0,   // line is not touched in this column
        LINE_LOW  = 2'd1,   // upper line of a compare-exchange pair
        LINE_HIGH = 2'd2    // lower line of a compare-exchange pair
    } line_role_e;

    // Distance between paired lines in column s.
    function automatic int column_span(input int n, input int s);
        return n >> (s + 1);
    endfunction

    // Role of line x in column s of the odd-even merge of two n/2 blocks.
    function automatic line_role_e line_role(input int n, input int s, input int x);
        int k;
        k = column_span(n, s);
        if (s == 0)
            return (x < k) ? LINE_LOW : LINE_HIGH;
        if (x < k || x >= n - k)
            return LINE_PASS;
        return ((((x - k) / k) % 2) == 0) ? LINE_LOW : LINE_HIGH;
    endfunction

endpackage

// File: rtl/oem_cmp_exch.sv
// Module: one compare-exchange cell. The smaller key goes to lo and the
// larger to hi. Equal keys are not swapped. Keys are unsigned.
module oem_cmp_exch #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic swap;

    // Swap only when the upper key is strictly greater than the lower one.
    always_comb begin
        swap = (b < a);
        lo   = swap ? b : a;
        hi   = swap ? a : b;
    end
endmodule

// File: rtl/oem_column.sv
// Module: one column of the odd-even merge network, with an optional
// register on its output. Assumes N is a power of two and S < log2(N).
module oem_column #(
    parameter int W   = 8,
    parameter int N   = 8,
    parameter int S   = 0,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N*W-1:0] in_keys,
    output logic         out_valid,
    output logic [N*W-1:0] out_keys
);
    localparam int K = oem_pkg::column_span(N, S);

    logic [W-1:0]   line_net [N];
    logic [N*W-1:0] comb_keys;

    // Place a cell on each upper line of a pair, and a wire on each idle line.
    for (genvar x = 0; x < N; x++) begin : g_line
        localparam oem_pkg::line_role_e ROLE = oem_pkg::line_role(N, S, x);
        if (ROLE == oem_pkg::LINE_LOW) begin : g_cell
            oem_cmp_exch #(.W(W)) u_cx (
                .a  (in_keys[x*W +: W]),
                .b  (in_keys[(x+K)*W +: W]),
                .lo (line_net[x]),
                .hi (line_net[x+K])
            );
        end else if (ROLE == oem_pkg::LINE_PASS) begin : g_wire
            assign line_net[x] = in_keys[x*W +: W];
        end
        assign comb_keys[x*W +: W] = line_net[x];
    end

    if (REG) begin : g_reg
        // Register the column output; the reset clears both data and strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_keys  <= '0;
            end else begin
                out_valid <= in_valid;
                out_keys  <= comb_keys;
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_keys  = comb_keys;
    end
endmodule

// File: rtl/oem_merge.sv
// Module: top of the odd-even merge network. It merges two nondecreasing
// blocks of N/2 unsigned keys into one nondecreasing vector of N keys.
// Assumes N is a power of two, 2 or larger, and that the caller supplies
// sorted blocks. REGISTERED=1 gives a latency of log2(N) cycles.
module oem_merge #(
    parameter int W          = 8,
    parameter int N          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N*W-1:0] in_keys,
    output logic         out_valid,
    output logic [N*W-1:0] out_keys
);
    localparam int COLS = $clog2(N);

    logic [N*W-1:0] chain_keys  [COLS+1];
    logic           chain_valid [COLS+1];

    assign chain_keys[0]  = in_keys;
    assign chain_valid[0] = in_valid;

    // Chain the columns, widest span first.
    for (genvar s = 0; s < COLS; s++) begin : g_col
        oem_column #(.W(W), .N(N), .S(s), .REG(REGISTERED)) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (chain_valid[s]),
            .in_keys   (chain_keys[s]),
            .out_valid (chain_valid[s+1]),
            .out_keys  (chain_keys[s+1])
        );
    end

    assign out_valid = chain_valid[COLS];
    assign out_keys  = chain_keys[COLS];
endmodule

// File: rtl/oem_merge_chk.sv
// Module: property checker for oem_merge. It delays a summary of each input
// vector (strobe, sortedness, key sum, end values) by the network latency
// and compares that summary with the outputs.
module oem_merge_chk #(
    parameter int W          = 8,
    parameter int N          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [N*W-1:0] in_keys,
    input logic         out_valid,
    input logic [N*W-1:0] out_keys
);
    localparam int COLS = $clog2(N);
    localparam int LAT  = REGISTERED ? COLS : 0;
    localparam int H    = N / 2;
    localparam int SW   = W + COLS + 1;

    logic          in_ok, out_sorted;
    logic [SW-1:0] in_sum, out_sum;
    logic [W-1:0]  in_min, in_max;

    // Summarise the input vector and the output vector.
    always_comb begin
        in_ok      = 1'b1;
        out_sorted = 1'b1;
        in_sum     = '0;
        out_sum    = '0;
        for (int i = 0; i < N; i++) begin
            in_sum  = in_sum  + SW'(in_keys[i*W +: W]);
            out_sum = out_sum + SW'(out_keys[i*W +: W]);
            if (i + 1 < N && out_keys[i*W +: W] > out_keys[(i+1)*W +: W])
                out_sorted = 1'b0;
            if (i + 1 < N && i != H - 1 && in_keys[i*W +: W] > in_keys[(i+1)*W +: W])
                in_ok = 1'b0;
        end
        in_min = (in_keys[0 +: W] < in_keys[H*W +: W]) ? in_keys[0 +: W] : in_keys[H*W +: W];
        in_max = (in_keys[(H-1)*W +: W] > in_keys[(N-1)*W +: W]) ?
                 in_keys[(H-1)*W +: W] : in_keys[(N-1)*W +: W];
    end

    logic          dv   [LAT+1];
    logic          dok  [LAT+1];
    logic [SW-1:0] dsum [LAT+1];
    logic [W-1:0]  dmin [LAT+1];
    logic [W-1:0]  dmax [LAT+1];

    assign dv[0]   = in_valid;
    assign dok[0]  = in_ok;
    assign dsum[0] = in_sum;
    assign dmin[0] = in_min;
    assign dmax[0] = in_max;

    // Delay line matching the network latency.
    for (genvar i = 1; i <= LAT; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) dv[i] <= 1'b0;
            else        dv[i] <= dv[i-1];
            dok[i]  <= dok[i-1];
            dsum[i] <= dsum[i-1];
            dmin[i] <= dmin[i-1];
            dmax[i] <= dmax[i-1];
        end
    end

    // R1: sorted blocks in give a nondecreasing vector out
    assert_sorted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dok[LAT]) |-> out_sorted);

    // R2: the key sum is preserved (permutation evidence)
    assert_keysum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum == dsum[LAT]));

    // R3: output ends equal the smaller head and the larger tail
    assert_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dok[LAT]) |->
        (out_keys[0 +: W] == dmin[LAT] && out_keys[(N-1)*W +: W] == dmax[LAT]));

    // R4: the strobe follows the input after exactly the latency
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == dv[LAT]);

    if (REGISTERED) begin : g_rst_chk
        // R6: the cycle after reset shows a cleared output
        assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (!out_valid && out_keys == '0));
    end
endmodule

bind oem_merge oem_merge_chk #(.W(W), .N(N), .REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_keys   (in_keys),
    .out_valid (out_valid),
    .out_keys  (out_keys)
);

// File: tb/tb_oem_merge.sv
// Bench: directed tests for oem_merge at N=8, W=8 with registered columns.
module tb_oem_merge;
    localparam int W   = 8;
    localparam int N   = 8;
    localparam int H   = N / 2;
    localparam int LAT = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [N*W-1:0] in_keys;
    logic           out_valid;
    logic [N*W-1:0] out_keys;

    always #5 clk = ~clk;

    oem_merge #(.W(W), .N(N), .REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_keys(in_keys),
        .out_valid(out_valid), .out_keys(out_keys)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int unsigned seed = 32'h1234_5678;

    logic [N*W-1:0] stim   [16];
    logic           stim_v [16];
    int             nstim;

    // Bubble-sort keys lo..hi of a packed vector (bench reference model).
    function automatic logic [N*W-1:0] sort_range(logic [N*W-1:0] v, int lo, int hi);
        logic [W-1:0] t;
        for (int i = lo; i < hi; i++)
            for (int j = lo; j < hi - (i - lo); j++)
                if (v[j*W +: W] > v[(j+1)*W +: W]) begin
                    t = v[j*W +: W];
                    v[j*W +: W] = v[(j+1)*W +: W];
                    v[(j+1)*W +: W] = t;
                end
        return v;
    endfunction

    // Pseudo-random vector whose two halves are each sorted.
    function automatic logic [N*W-1:0] rand_halves(ref int unsigned s);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            v[i*W +: W] = s[23:16];
        end
        v = sort_range(v, 0, H-1);
        return sort_range(v, H, N-1);
    endfunction

    task automatic check_keys(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: keys got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: bit got %b expected %b", tag, act, exp);
        end
    endtask

    // Stream stim[0..nstim-1] one per cycle; check each result LAT cycles later.
    task automatic run_stream(string tag);
        for (int k = 0; k < nstim + LAT; k++) begin
            @(negedge clk);
            if (k >= LAT) begin
                check_bit("R4", out_valid, stim_v[k-LAT]);
                if (stim_v[k-LAT])
                    check_keys(tag, out_keys, sort_range(stim[k-LAT], 0, N-1));
            end else begin
                check_bit("R4", out_valid, 1'b0);
            end
            if (k < nstim) begin
                in_valid = stim_v[k];
                in_keys  = stim[k];
            end else begin
                in_valid = 1'b0;
                in_keys  = '0;
            end
        end
    endtask

    task automatic load_one(logic [N*W-1:0] v);
        stim[0] = v; stim_v[0] = 1'b1; nstim = 1;
    endtask

    // R6: outputs are cleared while reset is held.
    task automatic t_reset_state();
        @(negedge clk);
        check_bit("R6", out_valid, 1'b0);
        check_keys("R6", out_keys, '0);
    endtask

    // R1: blocks 2,4,7,8 and 1,3,5,6 (key 0 at the lowest bits).
    task automatic t_example();
        load_one(64'h06_05_03_01_08_07_04_02);
        run_stream("R1");
    endtask

    // R7 and R3: one block lies wholly below the other, in both orders.
    task automatic t_disjoint();
        load_one(64'h50_40_30_20_10_0C_08_04);
        run_stream("R7");
        load_one(64'h04_03_02_01_80_70_60_50);
        run_stream("R3");
    endtask

    // R8: duplicates across the blocks and an all-equal vector.
    task automatic t_duplicates();
        load_one(64'h09_09_09_05_09_09_05_05);
        run_stream("R8");
        load_one({N{8'h33}});
        run_stream("R8");
    endtask

    // R9: the extreme values 0 and 255.
    task automatic t_extremes();
        load_one(64'hFF_FE_01_00_FF_FF_80_00);
        run_stream("R9");
        load_one(64'hFF_FF_FF_FF_00_00_00_00);
        run_stream("R9");
    endtask

    // R2 and R5: back-to-back pseudo-random vectors.
    task automatic t_random_stream();
        nstim = 12;
        for (int i = 0; i < nstim; i++) begin
            stim[i]   = rand_halves(seed);
            stim_v[i] = 1'b1;
        end
        run_stream("R2");
    endtask

    // R5: gaps in the strobe are reproduced at the output.
    task automatic t_gapped_stream();
        nstim = 10;
        for (int i = 0; i < nstim; i++) begin
            stim[i]   = rand_halves(seed);
            stim_v[i] = (i % 3) != 1;
        end
        run_stream("R5");
    endtask

    // R6: a reset in mid-flight drops the pending result.
    task automatic t_mid_reset();
        @(negedge clk);
        in_valid = 1'b1;
        in_keys  = rand_halves(seed);
        @(negedge clk);
        in_valid = 1'b0;
        in_keys  = '0;
        rst_n    = 1'b0;
        @(negedge clk);
        check_bit("R6", out_valid, 1'b0);
        check_keys("R6", out_keys, '0);
        rst_n = 1'b1;
        for (int i = 0; i <= LAT; i++) begin
            @(negedge clk);
            check_bit("R6", out_valid, 1'b0);
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_keys  = '0;
        repeat (3) @(posedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_example();
        t_disjoint();
        t_duplicates();
        t_extremes();
        t_random_stream();
        t_gapped_stream();
        t_mid_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(100_000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule